// File: doc/BRIEF.md
# Floating-Point Pack and Classify Unit

This block moves values between the packed IEEE binary32 word (binary64 through parameters) and a wide internal working form. The working form has five parts. A 3-bit class code. A sign. A signed unbiased exponent. A fraction with the leading one written out, followed by a set of guard bits that arithmetic units use for rounding.

The unpack path reads the sign, exponent and fraction fields of a packed word. It classifies the word and fills in the working form. Subnormal inputs are normalized on the way in. The pack path takes a working-form value and produces a packed word:

- It rounds to nearest-even.
- It folds an exponent that is too large into infinity.
- It shifts an exponent below the normal range into a subnormal, and shifts it to zero when it is far enough below.
- It forces NaN payloads into the right class.

A build option flips the meaning of the quiet-NaN bit. The two paths are independent and work side by side. A parameter chooses whether both sit behind one output register stage or are purely combinational.

Top module: `fp_pack_unit`

## Requirements
- R1: Class codes are 0 zero, 1 number, 2 subnormal, 3 infinity, 4 quiet NaN and 5 signalling NaN. Unpack never emits 6 or 7. In the packed word the sign is the top bit, the exponent field sits below it, and the fraction field is in the low bits. A word whose exponent field is neither all zeros nor all ones unpacks as class 1. Its exponent is the field minus the bias (127 for 8 exponent bits). Its fraction is a one, then the fraction field, then GRD_W zero bits.
- R2: A word whose exponent field and fraction field are both zero unpacks as class 0. The sign is kept, and the exponent and fraction are zero.
- R3: A zero exponent field with a nonzero fraction unpacks as class 2. The value is normalized so that the fraction's top bit is one. The exponent is (1 − bias) minus the distance the field's top set bit had to travel to reach the implicit-one position.
- R4: An all-ones exponent field with a zero fraction unpacks as class 3, with exponent and fraction zero.
- R5: An all-ones exponent field with a nonzero fraction unpacks as a NaN with exponent 0, and with the fraction field shifted up by GRD_W. With the default polarity the NaN is quiet (class 4) when the top fraction bit is 1, and signalling (class 5) otherwise.
- R6: With the negated polarity option, unpack treats the NaN as quiet when the top fraction bit is 0. When packing a quiet NaN it sets every fraction bit below the top bit. When packing a signalling NaN it sets the top bit.
- R7: With the default polarity, packing a quiet NaN sets the top fraction bit and packing a signalling NaN clears it. All other payload bits are the working fraction shifted down by GRD_W. Codes 6 and 7 pack as a quiet NaN.
- R8: A class 1 or 2 value whose exponent lies in [1 − bias, bias] is rounded to nearest on its GRD_W guard bits. An exact half rounds to the even result. The exponent field is the exponent plus the bias.
- R9: If rounding carries out above the implicit one, the exponent rises by one and the fraction field becomes zero. A carry from exponent = bias gives infinity.
- R10: A class 1 or 2 value with exponent above the bias packs as signed infinity with a zero fraction.
- R11: A class 1 or 2 value with exponent below 1 − bias packs with a zero exponent field. Its fraction is the leading-one significand shifted right by the shortfall, and dropped bits are truncated. A shortfall larger than the fraction width gives a signed zero.
- R12: Class 0 packs as a signed zero and class 3 packs as a signed infinity, whatever the exponent and fraction inputs are.
- R13: With REG_IO set, every output reflects the inputs of the previous clock, and a synchronous reset clears all outputs to zero. The unpack and pack paths work independently within the same cycle.
- R14: With the default polarity, packing the unpacked form of any non-NaN word or canonical NaN word returns the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_word_i | input | 1+EXP_W+FRAC_W | Packed word to unpack |
| up_class_o | output | 3 | Class code of the unpacked word |
| up_sign_o | output | 1 | Sign of the unpacked word |
| up_exp_o | output | EXP_W+2 | Signed unbiased exponent |
| up_frac_o | output | 1+FRAC_W+GRD_W | Fraction with explicit leading one and guard bits |
| pk_class_i | input | 3 | Class code to pack |
| pk_sign_i | input | 1 | Sign to pack |
| pk_exp_i | input | EXP_W+2 | Signed unbiased exponent to pack |
| pk_frac_i | input | 1+FRAC_W+GRD_W | Working fraction to pack |
| pk_word_o | output | 1+EXP_W+FRAC_W | Packed result |

## Verification
The unpack and pack paths share a clock and a register stage. The bench drives a fresh word and an unrelated working-form value in every cycle, and checks both results together against a behavioural model. A loopback phase feeds each cycle's unpack result into the pack inputs on the next cycle, while a new word goes into unpack at the same time. The packed word must then match the word given two cycles earlier. A second instance built with the negated polarity runs on the same stimulus, so NaN handling is judged for both settings on identical inputs.

// File: rtl/fpk_pkg.sv
package fpk_pkg;

  typedef enum logic [2:0] {
    FC_ZERO = 3'd0,
    FC_NUM  = 3'd1,
    FC_DEN  = 3'd2,
    FC_INF  = 3'd3,
    FC_QNAN = 3'd4,
    FC_SNAN = 3'd5
  } fclass_e;

endpackage

// File: rtl/fpk_unpack.sv
module fpk_unpack #(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int GRD_W    = 7,
  parameter bit QNAN_NEG = 1'b0,
  localparam int W  = 1 + EXP_W + FRAC_W,
  localparam int MW = 1 + FRAC_W + GRD_W,
  localparam int XW = EXP_W + 2
) (
  input  logic [W-1:0]          word_i,
  output logic [2:0]            cls_o,
  output logic                  sign_o,
  output logic signed [XW-1:0]  exp_o,
  output logic [MW-1:0]         frac_o
);
  import fpk_pkg::*;

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int CW   = $clog2(FRAC_W + 1);
  localparam logic signed [XW-1:0] E_MIN = XW'(1 - BIAS);
  localparam logic signed [XW-1:0] E_BIAS = XW'(BIAS);

  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] ff;
  logic [CW-1:0]     lz;
  logic              hit;
  logic [FRAC_W:0]   den;

  assign ef = word_i[W-2:FRAC_W];
  assign ff = word_i[FRAC_W-1:0];

  // leading-zero count of the fraction field
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (ff[i]) hit = 1'b1;
        else       lz  = lz + CW'(1);
      end
    end
  end

  // subnormal normalized so its top set bit lands on the implicit position
  assign den = {ff, 1'b0} << lz;

  always_comb begin
    cls_o  = FC_ZERO;
    sign_o = word_i[W-1];
    exp_o  = '0;
    frac_o = '0;
    if (ef == '0) begin
      if (ff != '0) begin
        cls_o  = FC_DEN;
        exp_o  = E_MIN - XW'(1) - XW'(lz);
        frac_o = {den, {GRD_W{1'b0}}};
      end
    end else if (ef == '1) begin
      if (ff == '0) begin
        cls_o = FC_INF;
      end else begin
        cls_o  = (ff[FRAC_W-1] ^ QNAN_NEG) ? FC_QNAN : FC_SNAN;
        frac_o = {1'b0, ff, {GRD_W{1'b0}}};
      end
    end else begin
      cls_o  = FC_NUM;
      exp_o  = XW'(ef) - E_BIAS;
      frac_o = {1'b1, ff, {GRD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/fpk_pack.sv
module fpk_pack #(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int GRD_W    = 7,
  parameter bit QNAN_NEG = 1'b0,
  localparam int W  = 1 + EXP_W + FRAC_W,
  localparam int MW = 1 + FRAC_W + GRD_W,
  localparam int XW = EXP_W + 2
) (
  input  logic [2:0]            cls_i,
  input  logic                  sign_i,
  input  logic signed [XW-1:0]  exp_i,
  input  logic [MW-1:0]         frac_i,
  output logic [W-1:0]          word_o
);
  import fpk_pkg::*;

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic signed [XW-1:0] E_MIN = XW'(1 - BIAS);
  localparam logic signed [XW-1:0] E_TOP = XW'(BIAS);
  localparam logic [GRD_W-1:0]  G_HALF = {1'b1, {(GRD_W-1){1'b0}}};
  localparam logic [GRD_W-1:0]  G_RND  = {1'b0, {(GRD_W-1){1'b1}}};
  localparam logic [FRAC_W-1:0] F_TOP  = {1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [FRAC_W-1:0] F_LOW  = {1'b0, {(FRAC_W-1){1'b1}}};

  logic [FRAC_W-1:0] pay, nan_q, nan_s;
  assign pay = frac_i[MW-2:GRD_W];

  generate
    if (QNAN_NEG) begin : g_nan_neg
      assign nan_q = pay | F_LOW;
      assign nan_s = pay | F_TOP;
    end else begin : g_nan_pos
      assign nan_q = pay | F_TOP;
      assign nan_s = pay & ~F_TOP;
    end
  endgenerate

  logic signed [XW:0]   shd;
  logic [FRAC_W:0]      mant;
  logic [GRD_W-1:0]     inc;
  logic [MW:0]          sum;
  logic signed [XW-1:0] ex;
  logic [EXP_W-1:0]     efld;
  logic [FRAC_W-1:0]    ffld;

  // denormalizing shift for under-range exponents
  assign shd  = E_MIN - exp_i;
  assign mant = frac_i[MW-1:GRD_W] >> shd;

  // nearest-even: exact half adds half only when the kept LSB is odd
  assign inc = (frac_i[GRD_W-1:0] == G_HALF) ? (frac_i[GRD_W] ? G_HALF : '0) : G_RND;
  assign sum = {1'b0, frac_i} + {{(MW + 1 - GRD_W){1'b0}}, inc};

  always_comb begin
    efld = '0;
    ffld = '0;
    ex   = exp_i;
    case (cls_i)
      FC_ZERO: begin
        efld = '0;
        ffld = '0;
      end
      FC_INF: begin
        efld = '1;
        ffld = '0;
      end
      FC_SNAN: begin
        efld = '1;
        ffld = nan_s;
      end
      FC_NUM, FC_DEN: begin
        if (exp_i < E_MIN) begin
          efld = '0;
          ffld = (shd > FRAC_W) ? '0 : mant[FRAC_W-1:0];
        end else if (exp_i > E_TOP) begin
          efld = '1;
          ffld = '0;
        end else begin
          if (sum[MW]) begin
            ex   = exp_i + XW'(1);
            ffld = sum[MW-1:GRD_W+1];
          end else begin
            ex   = exp_i;
            ffld = sum[MW-2:GRD_W];
          end
          efld = EXP_W'(ex + E_TOP);
        end
      end
      default: begin
        efld = '1;
        ffld = nan_q;
      end
    endcase
  end

  assign word_o = {sign_i, efld, ffld};

endmodule

// File: rtl/fp_pack_unit.sv
module fp_pack_unit #(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int GRD_W    = 7,
  parameter bit QNAN_NEG = 1'b0,
  parameter bit REG_IO   = 1'b1,
  localparam int W  = 1 + EXP_W + FRAC_W,
  localparam int MW = 1 + FRAC_W + GRD_W,
  localparam int XW = EXP_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [W-1:0]          up_word_i,
  output logic [2:0]            up_class_o,
  output logic                  up_sign_o,
  output logic signed [XW-1:0]  up_exp_o,
  output logic [MW-1:0]         up_frac_o,
  input  logic [2:0]            pk_class_i,
  input  logic                  pk_sign_i,
  input  logic signed [XW-1:0]  pk_exp_i,
  input  logic [MW-1:0]         pk_frac_i,
  output logic [W-1:0]          pk_word_o
);
  import fpk_pkg::*;

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int TINY = 1 - BIAS - FRAC_W;

  logic [2:0]           u_cls;
  logic                 u_sign;
  logic signed [XW-1:0] u_exp;
  logic [MW-1:0]        u_frac;
  logic [W-1:0]         p_word;

  fpk_unpack #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD_W(GRD_W), .QNAN_NEG(QNAN_NEG)
  ) u_unpack (
    .word_i (up_word_i),
    .cls_o  (u_cls),
    .sign_o (u_sign),
    .exp_o  (u_exp),
    .frac_o (u_frac)
  );

  fpk_pack #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD_W(GRD_W), .QNAN_NEG(QNAN_NEG)
  ) u_pack (
    .cls_i  (pk_class_i),
    .sign_i (pk_sign_i),
    .exp_i  (pk_exp_i),
    .frac_i (pk_frac_i),
    .word_o (p_word)
  );

  generate
    if (REG_IO) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          up_class_o <= '0;
          up_sign_o  <= 1'b0;
          up_exp_o   <= '0;
          up_frac_o  <= '0;
          pk_word_o  <= '0;
        end else begin
          up_class_o <= u_cls;
          up_sign_o  <= u_sign;
          up_exp_o   <= u_exp;
          up_frac_o  <= u_frac;
          pk_word_o  <= p_word;
        end
      end
    end else begin : g_comb
      assign up_class_o = u_cls;
      assign up_sign_o  = u_sign;
      assign up_exp_o   = u_exp;
      assign up_frac_o  = u_frac;
      assign pk_word_o  = p_word;
    end
  endgenerate

  // R1
  unpack_class_range_chk: assert property (@(posedge clk) disable iff (rst)
    u_cls <= 3'd5);

  // R2
  zero_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (u_cls == FC_ZERO) |-> (u_exp == '0 && u_frac == '0));

  // R3
  lead_one_chk: assert property (@(posedge clk) disable iff (rst)
    (u_cls == FC_NUM || u_cls == FC_DEN) |-> u_frac[MW-1]);

  // R12
  inf_encode_chk: assert property (@(posedge clk) disable iff (rst)
    (pk_class_i == FC_INF) |->
      (p_word[W-2:FRAC_W] == '1 && p_word[FRAC_W-1:0] == '0 && p_word[W-1] == pk_sign_i));

  // R10
  exp_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    ((pk_class_i == FC_NUM || pk_class_i == FC_DEN) && pk_exp_i > BIAS) |->
      (p_word[W-2:FRAC_W] == '1 && p_word[FRAC_W-1:0] == '0));

  // R11
  tiny_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((pk_class_i == FC_NUM || pk_class_i == FC_DEN) && pk_exp_i < TINY) |->
      (p_word[W-2:0] == '0 && p_word[W-1] == pk_sign_i));

endmodule

// File: tb/tb_fp_pack_unit.sv
`timescale 1ns/1ps
module tb_fp_pack_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] up_word = '0;
  logic [2:0]  pk_cls = '0;
  logic        pk_sign = 1'b0;
  logic signed [9:0] pk_exp = '0;
  logic [30:0] pk_frac = '0;

  logic [2:0]  a_cls, b_cls;
  logic        a_sign, b_sign;
  logic signed [9:0] a_exp, b_exp;
  logic [30:0] a_frac, b_frac;
  logic [31:0] a_word, b_word;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  fp_pack_unit dut (
    .clk(clk), .rst(rst), .up_word_i(up_word),
    .up_class_o(a_cls), .up_sign_o(a_sign), .up_exp_o(a_exp), .up_frac_o(a_frac),
    .pk_class_i(pk_cls), .pk_sign_i(pk_sign), .pk_exp_i(pk_exp), .pk_frac_i(pk_frac),
    .pk_word_o(a_word)
  );

  fp_pack_unit #(.QNAN_NEG(1'b1)) dut_neg (
    .clk(clk), .rst(rst), .up_word_i(up_word),
    .up_class_o(b_cls), .up_sign_o(b_sign), .up_exp_o(b_exp), .up_frac_o(b_frac),
    .pk_class_i(pk_cls), .pk_sign_i(pk_sign), .pk_exp_i(pk_exp), .pk_frac_i(pk_frac),
    .pk_word_o(b_word)
  );

  task automatic check(string tag, string what, longint act, longint expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic void ref_unpack(input logic [31:0] w, input bit neg,
                                     output int c, output bit s, output int e, output longint f);
    int ef;
    longint fr;
    int top;
    ef  = int'(w[30:23]);
    fr  = longint'(w[22:0]);
    s   = w[31];
    c   = 0; e = 0; f = 0;
    if (ef == 0) begin
      if (fr != 0) begin
        top = 0;
        for (int i = 0; i < 23; i++) if (w[i]) top = i;
        c = 2;
        e = -149 + top;
        f = fr << (30 - top);
      end
    end else if (ef == 255) begin
      if (fr == 0) c = 3;
      else begin
        c = (w[22] ^ neg) ? 4 : 5;
        f = fr << 7;
      end
    end else begin
      c = 1;
      e = ef - 127;
      f = (fr + (longint'(1) << 23)) << 7;
    end
  endfunction

  function automatic logic [31:0] ref_pack(input int c, input bit s, input int e,
                                           input longint f, input bit neg);
    longint p, q, r;
    int ee;
    p = (f >> 7) & 'h7FFFFF;
    case (c)
      0: return {s, 31'h0};
      3: return {s, 8'hFF, 23'h0};
      5: return {s, 8'hFF, 23'(neg ? (p | 'h400000) : (p & 'h3FFFFF))};
      1, 2: begin
        if (e < -126) begin
          if (-126 - e > 23) return {s, 31'h0};
          return {s, 8'h00, 23'((f >> 7) >> (-126 - e))};
        end
        if (e > 127) return {s, 8'hFF, 23'h0};
        q = f >> 7;
        r = f % 128;
        ee = e;
        if (r > 64 || (r == 64 && (q % 2) == 1)) q = q + 1;
        if (q >= (longint'(1) << 24)) begin
          q = q >> 1;
          ee = ee + 1;
        end
        return {s, 8'(ee + 127), 23'(q)};
      end
      default: return {s, 8'hFF, 23'(neg ? (p | 'h3FFFFF) : (p | 'h400000))};
    endcase
  endfunction

  // drive one vector at a negedge, compare both instances one clock later
  task automatic apply(string tag, logic [31:0] w, logic [2:0] c, bit s, int e, longint f);
    int ac, bc, ae, be;
    bit as_, bs_;
    longint af, bf;
    logic [31:0] aw, bw;
    ref_unpack(w, 1'b0, ac, as_, ae, af);
    ref_unpack(w, 1'b1, bc, bs_, be, bf);
    aw = ref_pack(int'(c), s, e, f, 1'b0);
    bw = ref_pack(int'(c), s, e, f, 1'b1);
    up_word = w;
    pk_cls  = c;
    pk_sign = s;
    pk_exp  = 10'(e);
    pk_frac = 31'(f);
    @(negedge clk);
    check(tag, "class", longint'(a_cls), longint'(ac));
    check(tag, "sign",  longint'(a_sign), longint'(as_));
    check(tag, "exp",   longint'(int'(a_exp)), longint'(ae));
    check(tag, "frac",  longint'(a_frac), af);
    check(tag, "word",  longint'(a_word), longint'(aw));
    check(tag, "neg class", longint'(b_cls), longint'(bc));
    check(tag, "neg exp",   longint'(int'(b_exp)), longint'(be));
    check(tag, "neg frac",  longint'(b_frac), bf);
    check(tag, "neg word",  longint'(b_word), longint'(bw));
  endtask

  logic [31:0] prev_w, next_w;
  logic [31:0] specials [10] = '{32'h00000000, 32'h80000000, 32'h7F800000, 32'hFF800000,
                                 32'h7FC00000, 32'h7F800001, 32'h00000001, 32'h807FFFFF,
                                 32'h00400000, 32'h7F7FFFFF};

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", "reset word", longint'(a_word), 0);
    check("R13", "reset class", longint'(a_cls), 0);
    check("R13", "reset frac", longint'(a_frac), 0);
    rst = 1'b0;

    // unpack directed words paired with pack directed values
    apply("R1",  32'h3F800000, 3'd1, 1'b0, 0,   31'h40000040);
    apply("R8",  32'hC0490FDB, 3'd1, 1'b0, 0,   31'h400000C0);
    apply("R8",  32'h00000000, 3'd1, 1'b0, 0,   31'h40000041);
    apply("R8",  32'h00000000, 3'd1, 1'b1, -3,  31'h4000003F);
    apply("R2",  32'h80000000, 3'd1, 1'b0, 0,   31'h7FFFFFFF);
    apply("R9",  32'h00000001, 3'd1, 1'b1, 127, 31'h7FFFFFFF);
    apply("R3",  32'h00400000, 3'd1, 1'b0, 128, 31'h40000000);
    apply("R10", 32'h807FFFFF, 3'd2, 1'b1, 200, 31'h40000000);
    apply("R4",  32'h7F800000, 3'd1, 1'b0, -127, 31'h40000000);
    apply("R11", 32'hFF800000, 3'd2, 1'b0, -149, 31'h40000000);
    apply("R11", 32'h00000000, 3'd1, 1'b1, -150, 31'h40000000);
    apply("R11", 32'h00000000, 3'd1, 1'b0, -140, 31'h7FFFFFFF);
    apply("R12", 32'h00000000, 3'd0, 1'b1, 5,   31'h12345678);
    apply("R12", 32'h00000000, 3'd3, 1'b0, -9,  31'h7FFFFFFF);
    apply("R5/R6", 32'h7FC00001, 3'd4, 1'b0, 0, 31'h00000000);
    apply("R5/R6", 32'h7F800001, 3'd5, 1'b1, 0, 31'h00000080);
    apply("R7",  32'hFFFFFFFF, 3'd6, 1'b0, 0,   31'h00000180);
    apply("R7",  32'h7FBFFFFF, 3'd7, 1'b1, 0,   31'h1FFFFF80);
    apply("R6",  32'hFFC00000, 3'd5, 1'b0, 0,   31'h3FFFFF80);

    // R14 loopback: last cycle's unpack result is packed while a new word unpacks
    prev_w = specials[0];
    apply("R14", prev_w, 3'd0, 1'b0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      if (i < 10) next_w = specials[i];
      else next_w = {1'($urandom), 8'($urandom_range(1, 254)), 23'($urandom)};
      apply("R14", next_w, a_cls, a_sign, int'(a_exp), longint'(a_frac));
      check("R14", "round trip", longint'(a_word), longint'(prev_w));
      prev_w = next_w;
    end

    // R13 both paths loaded with unrelated random stimulus every cycle
    for (int i = 0; i < 1500; i++) begin
      apply("R13", 32'($urandom), 3'($urandom_range(0, 7)), 1'($urandom),
            int'($urandom_range(0, 300)) - 160, longint'({1'b1, 30'($urandom)}));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule